// File: doc/BRIEF.md
# Fan PWM and Tachometer Controller

This block drives one cooling fan. Software writes a duty value and a clock divider through a small 32-bit register port. The block then produces a pulse-width modulated pin whose period is 256 steps of (divider + 1) system clocks each. The pin can be inverted, gated off, or driven as an open-collector output. In open-collector mode the pad is pulled low only through the output-enable signal.

The fan's tachometer line is brought into the clock domain and its rising edges are counted over a fixed window. The window length is a parameter in system clocks and defaults to one second at 200 MHz. At the end of each window the count is placed in a read-only register and counting starts again. Software converts pulses per window into revolutions per minute.

Top module: `fan_ctrl`

## Requirements
- R1: After reset every register reads 0. Reading byte offset 0x0 returns the duty in bits 23:16 and the control nibble in bits 3:0, where bit 3 is invert, bit 2 is gate, bit 1 is open-collector and bit 0 is a spare flag. Reading offset 0x4 returns the divider in bits 14:0 and a stored 11-bit cycle-time field in bits 25:15. All other bits read 0.
- R2: A write to offset 0xC (tach count) or to an unmapped offset changes no register.
- R3: The PWM period is 256*(divider+1) clocks. Within each period, the internal level is high for duty*(divider+1) clocks.
- R4: A duty of 0 keeps the level low for the whole period. A duty of 255 keeps it high for 255 of the 256 steps.
- R5: A new duty or divider takes effect only at the next period start, so the first full pulse after a change has the new length.
- R6: With invert set, the level driven out is the complement of the internal level.
- R7: With gate clear, the internal level is forced low before inversion. The pin therefore sits at its inactive level.
- R8: In push-pull mode, pwm_out carries the level and pwm_oe is 1. In open-collector mode, pwm_out is 0 and pwm_oe is 1 exactly when the level is low.
- R9: Rising edges on tach_in, after a two-flop synchroniser, are counted over each window of WINDOW_CLKS clocks. At the window end the count is placed in offset 0xC bits 15:0 and the counter restarts from zero.
- R10: The latched tach count saturates at its all-ones value (65535 for the default width).
- R11: After reset, pwm_out is 0 and pwm_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tach_in | input | 1 | Asynchronous tachometer input |
| pwm_out | output | 1 | PWM pin level |
| pwm_oe | output | 1 | Pad output enable |

## Verification
The PWM is driven from a table of settings. The table covers duty at 0, 1, mid-range and 255 and dividers from 0 to 3. The high cycles of pwm_out and pwm_oe are counted over one full period, which separates a wrong step count from a wrong prescale. Invert, gate and open-collector combinations are included so each output mapping gives a distinct pair of counts. A run-length test after a mid-period duty change separates period-aligned updates from immediate ones. Tach tests use a steady edge rate, then silence to confirm the count restarts, then an over-range rate on a narrow-counter instance to reach saturation.

// File: rtl/fan_pkg.sv
// Shared register layout and control-bit type for the fan controller.
// Assumes byte offsets on a 4-bit address and 32-bit data.
package fan_pkg;
    localparam int BUS_AW   = 4;
    localparam int BUS_DW   = 32;
    localparam int DUTY_W   = 8;
    localparam int DUTY_LSB = 16;
    localparam int DIV_W    = 15;
    localparam int CYC_W    = 11;
    localparam int CYC_LSB  = DIV_W;
    localparam int CTL_W    = 4;

    localparam logic [BUS_AW-1:0] OFF_CFG  = 4'h0;
    localparam logic [BUS_AW-1:0] OFF_FREQ = 4'h4;
    localparam logic [BUS_AW-1:0] OFF_TACH = 4'hC;

    // Control nibble; the field order is the bit order of the config word.
    typedef struct packed {
        logic inv;
        logic gate;
        logic oc;
        logic aux;
    } fan_ctl_t;
endpackage

// File: rtl/fan_regs.sv
// Register file: holds config and frequency words and muxes read data.
// Assumes single-cycle writes; the tach count is read-only and supplied from outside.
module fan_regs
    import fan_pkg::*;
#(
    parameter int TACH_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [TACH_W-1:0] tach_cnt,
    output logic [DUTY_W-1:0] duty,
    output logic [DIV_W-1:0]  divider,
    output fan_ctl_t          ctl
);
    logic [CYC_W-1:0] cyc_q;

    // Capture writes to the two writable words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty    <= '0;
            ctl     <= '0;
            divider <= '0;
            cyc_q   <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFF_CFG) begin
                duty <= bus_wdata[DUTY_LSB +: DUTY_W];
                ctl  <= fan_ctl_t'(bus_wdata[CTL_W-1:0]);
            end
            if (bus_addr == OFF_FREQ) begin
                divider <= bus_wdata[DIV_W-1:0];
                cyc_q   <= bus_wdata[CYC_LSB +: CYC_W];
            end
        end
    end

    // Read mux; unused bits return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CFG: begin
                bus_rdata[DUTY_LSB +: DUTY_W] = duty;
                bus_rdata[CTL_W-1:0]          = ctl;
            end
            OFF_FREQ: begin
                bus_rdata[CYC_LSB +: CYC_W] = cyc_q;
                bus_rdata[DIV_W-1:0]        = divider;
            end
            OFF_TACH: bus_rdata[TACH_W-1:0] = tach_cnt;
            default:  bus_rdata = '0;
        endcase
    end

    a_r2_cfg_write_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != OFF_CFG) |=> ($stable(duty) && $stable(ctl)));
    a_r2_freq_write_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != OFF_FREQ) |=> ($stable(divider) && $stable(cyc_q)));
endmodule

// File: rtl/fan_pwm_gen.sv
// PWM generator: prescaler, 256-step counter, shadowed duty/divider, output stage.
// Assumes requested settings may change at any clock; they load at period start.
module fan_pwm_gen
    import fan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_req,
    input  logic [DIV_W-1:0]  div_req,
    input  fan_ctl_t          ctl,
    output logic              pwm_out,
    output logic              pwm_oe
);
    logic [DIV_W-1:0]  pre_q;
    logic [DIV_W-1:0]  div_act;
    logic [DUTY_W-1:0] duty_act;
    logic [DUTY_W-1:0] step_q;
    logic              tick;
    logic              wrap;
    logic              raw;
    logic              level;

    assign tick = (pre_q == div_act);
    assign wrap = tick && (step_q == '1);

    // Prescaler: one tick every (divider + 1) clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end

    // Step counter advances once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    step_q <= '0;
        else if (tick) step_q <= step_q + 1'b1;
    end

    // Shadow settings load only at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_act <= '0;
            div_act  <= '0;
        end else if (wrap) begin
            duty_act <= duty_req;
            div_act  <= div_req;
        end
    end

    // Output stage: compare, gate, polarity, drive mode.
    always_comb begin
        raw   = (step_q < duty_act) && ctl.gate;
        level = raw ^ ctl.inv;
        if (ctl.oc) begin
            pwm_out = 1'b0;
            pwm_oe  = ~level;
        end else begin
            pwm_out = level;
            pwm_oe  = 1'b1;
        end
    end

    a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(duty_act) && $stable(div_act)));
    a_r3_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(step_q));
    a_r8_oc_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.oc |-> !pwm_out);
    a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.gate && !ctl.oc) |-> (pwm_out == ctl.inv));
endmodule

// File: rtl/fan_tach.sv
// Tachometer counter: two-flop synchroniser, rising-edge count per window, saturating latch.
// Assumes tach_in is asynchronous and slower than half the clock rate.
module fan_tach #(
    parameter int TACH_W      = 16,
    parameter int WINDOW_CLKS = 200_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tach_in,
    output logic [TACH_W-1:0] tach_cnt
);
    localparam int WIN_W = (WINDOW_CLKS > 1) ? $clog2(WINDOW_CLKS) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_CLKS - 1);

    logic [2:0]        sync_q;
    logic [WIN_W-1:0]  win_q;
    logic [TACH_W-1:0] acc_q;
    logic [TACH_W-1:0] acc_next;
    logic              rise;
    logic              win_end;

    assign rise    = sync_q[1] & ~sync_q[2];
    assign win_end = (win_q == WIN_LAST);
    assign acc_next = (rise && acc_q != '1) ? acc_q + 1'b1 : acc_q;

    // Synchronise the tach line and keep one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], tach_in};
    end

    // Window counter.
    always_ff @(posedge clk) begin
        if (!rst_n)       win_q <= '0;
        else if (win_end) win_q <= '0;
        else              win_q <= win_q + 1'b1;
    end

    // Accumulate edges; latch and clear at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            tach_cnt <= '0;
        end else if (win_end) begin
            acc_q    <= '0;
            tach_cnt <= acc_next;
        end else begin
            acc_q <= acc_next;
        end
    end

    a_r9_latch_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(tach_cnt));
    a_r10_acc_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q == '1 && !win_end) |=> (acc_q == '1));
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (acc_q == '0));
endmodule

// File: rtl/fan_ctrl.sv
// Fan controller top: register port, PWM generator and tachometer counter.
// Assumes a single fan channel and a synchronous active-low reset.
module fan_ctrl
    import fan_pkg::*;
#(
    parameter int TACH_W      = 16,
    parameter int WINDOW_CLKS = 200_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic              tach_in,
    output logic              pwm_out,
    output logic              pwm_oe
);
    logic [DUTY_W-1:0] duty;
    logic [DIV_W-1:0]  divider;
    fan_ctl_t          ctl;
    logic [TACH_W-1:0] tach_cnt;

    fan_regs #(.TACH_W(TACH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tach_cnt(tach_cnt),
        .duty(duty), .divider(divider), .ctl(ctl)
    );

    fan_pwm_gen u_pwm (
        .clk(clk), .rst_n(rst_n), .duty_req(duty), .div_req(divider),
        .ctl(ctl), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    fan_tach #(.TACH_W(TACH_W), .WINDOW_CLKS(WINDOW_CLKS)) u_tach (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .tach_cnt(tach_cnt)
    );
endmodule

// File: tb/fan_ctrl_test.sv
// Bench for fan_ctrl: table-driven PWM checks, then directed register, update and tach tests.
module fan_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tach_in = 1'b0;
    logic        pwm_out, pwm_oe;
    logic [31:0] sat_rdata;
    logic        sat_tach = 1'b0;
    logic        sat_out, sat_oe;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit tach_run = 0;
    bit sat_run = 0;

    always #2.5 clk = ~clk;

    fan_ctrl #(.TACH_W(16), .WINDOW_CLKS(2000)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tach_in(tach_in),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    fan_ctrl #(.TACH_W(8), .WINDOW_CLKS(2000)) uut_sat (
        .clk(clk), .rst_n(rst_n), .bus_addr(4'hC), .bus_wr(1'b0),
        .bus_wdata(32'h0), .bus_rdata(sat_rdata), .tach_in(sat_tach),
        .pwm_out(sat_out), .pwm_oe(sat_oe)
    );

    // duty, divider, ctl {inv,gate,oc,aux}, expected pwm_out-high, expected pwm_oe-high per period
    typedef struct packed {
        logic [7:0]  duty;
        logic [14:0] dv;
        logic [3:0]  ctl;
        logic [15:0] out_hi;
        logic [15:0] oe_hi;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'd128, 15'd0, 4'b0100, 16'd128, 16'd256},
        '{8'd0,   15'd0, 4'b0100, 16'd0,   16'd256},
        '{8'd255, 15'd0, 4'b0100, 16'd255, 16'd256},
        '{8'd64,  15'd1, 4'b0100, 16'd128, 16'd512},
        '{8'd64,  15'd1, 4'b1100, 16'd384, 16'd512},
        '{8'd100, 15'd2, 4'b0110, 16'd0,   16'd468},
        '{8'd100, 15'd2, 4'b0000, 16'd0,   16'd768},
        '{8'd100, 15'd2, 4'b1000, 16'd768, 16'd768},
        '{8'd200, 15'd0, 4'b1110, 16'd0,   16'd200},
        '{8'd1,   15'd3, 4'b0100, 16'd4,   16'd1024}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<190000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Tach stimulus: 20-clock period square wave for uut, toggling every clock for uut_sat.
    always @(negedge clk) begin
        if (sat_run) sat_tach <= ~sat_tach;
        else         sat_tach <= 1'b0;
    end
    initial begin
        forever begin
            @(negedge clk);
            if (tach_run) begin
                tach_in = 1'b1;
                wait_clks(10);
                tach_in = 1'b0;
                wait_clks(9);
            end
        end
    end

    initial begin
        logic [31:0] d;
        int hi_out, hi_oe, per, run, waited;

        wait_clks(5);
        @(negedge clk) rst_n = 1'b1;

        // R11 / R1 reset state
        #1;
        chk("R11 pwm_out after reset", int'(pwm_out), 0);
        chk("R11 pwm_oe after reset", int'(pwm_oe), 1);
        rd(4'h0, d); chk("R1 cfg reset", int'(d), 0);
        rd(4'h4, d); chk("R1 freq reset", int'(d), 0);
        rd(4'hC, d); chk("R1 tach reset", int'(d), 0);

        // R3 R4 R6 R7 R8 table walk
        foreach (VECS[k]) begin
            wr(4'h0, (32'(VECS[k].duty) << 16) | 32'(VECS[k].ctl));
            wr(4'h4, 32'(VECS[k].dv));
            wait_clks(2100);
            per = 256 * (int'(VECS[k].dv) + 1);
            hi_out = 0;
            hi_oe = 0;
            for (int i = 0; i < per; i++) begin
                @(negedge clk);
                hi_out += int'(pwm_out);
                hi_oe  += int'(pwm_oe);
            end
            chk($sformatf("R3/R4/R6/R7/R8 vec%0d pwm_out high count", k), hi_out, int'(VECS[k].out_hi));
            chk($sformatf("R3/R4/R6/R7/R8 vec%0d pwm_oe high count", k), hi_oe, int'(VECS[k].oe_hi));
        end

        // R1 readback and unused bits masked
        wr(4'h0, 32'hFFAB_FFFD);
        rd(4'h0, d); chk("R1 cfg readback", int'(d), int'(32'h00AB_000D));
        wr(4'h4, (32'h5A5 << 15) | 32'h3 | 32'hFC00_0000);
        rd(4'h4, d); chk("R1 freq readback", int'(d), int'((32'h5A5 << 15) | 32'h3));

        // R2 writes to tach and unmapped offsets change nothing
        wr(4'hC, 32'hFFFF_FFFF);
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'hC, d); chk("R2 tach not writable", int'(d), 0);
        rd(4'h0, d); chk("R2 cfg unchanged", int'(d), int'(32'h00AB_000D));
        rd(4'h4, d); chk("R2 freq unchanged", int'(d), int'((32'h5A5 << 15) | 32'h3));

        // R5 duty change mid-period: first high pulse must be complete
        wr(4'h0, 32'h0000_0004);
        wr(4'h4, 32'h3);
        wait_clks(2100);
        wr(4'h0, 32'h00FF_0004);
        waited = 0;
        while (!pwm_out && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        run = 0;
        while (pwm_out && run < 3000) begin
            @(negedge clk);
            run++;
        end
        chk("R5 first pulse length after update", run, 1020);

        // R9 steady edges: 100 per 2000-clock window
        tach_run = 1;
        wait_clks(4100);
        rd(4'hC, d); chk("R9 tach count 100", int'(d), 100);
        tach_run = 0;
        wait_clks(4100);
        rd(4'hC, d); chk("R9 tach restarts to 0", int'(d), 0);

        // R10 saturation on the narrow-counter instance
        sat_run = 1;
        wait_clks(4100);
        #1 chk("R10 tach saturates", int'(sat_rdata), 255);
        sat_run = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule